// File: doc/BRIEF.md
# Parity-Protected Shared Memory

This block wraps a dual-client shared memory and adds a seventeenth bit to every stored word. Two clients reach the memory through one array: an internal port, used by the protocol engine, and a host port, used by the processor. When both request access in the same cycle, the internal port wins. The host is held back through a ready signal until the internal port is idle.

On each write the block computes an odd-parity bit over the 16 data bits and stores it with the word. On each read the block recomputes parity over all 17 stored bits. A mismatch produces a one-cycle error pulse. The pulse appears in the same cycle as the read data. It carries the word address and the port that issued the read, so the error can be logged and turned into an interrupt. The same pulse sets a sticky flag, which stays set until the host clears it.

A fault-injection input flips the stored parity bit on writes. This lets the checker be exercised without faulty memory.

Top module: `parity_shared_mem`

## Requirements
- R1: Each stored word is DW+1 bits wide: the data plus one parity bit, chosen so that the total number of ones in the word is odd. A read returns the data bits unchanged.
- R2: A read accepted on a port raises that port's read-valid output (host_rvalid or int_rvalid) in the next cycle, with the data on its read-data output. A write raises no read-valid output.
- R3: When int_req and host_req are both high, the internal access is performed. host_ready is low and the host access is not performed in that cycle.
- R4: host_ready is high whenever int_req is low. A host request that is held into the next cycle is then served.
- R5: Every read on either port is checked. A parity mismatch raises err_pulse in the same cycle as the read-valid output. In that cycle err_addr gives the read address and err_src gives the requesting port (1 = internal, 0 = host).
- R6: A read of a word written with correct parity leaves err_pulse low.
- R7: err_sticky is set by err_pulse and holds until err_clr is high in a cycle without err_pulse. When both occur in the same cycle, the set wins.
- R8: While inject_err is high, writes store the inverted parity bit and leave the data bits intact. A later write without inject_err stores good parity again.
- R9: After reset, host_rvalid, int_rvalid, err_pulse and err_sticky are low.
- R10: An all-zero stored word is flagged as an error. Writing data 0 with inject_err high produces such a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_req | input | 1 | Internal port request |
| int_we | input | 1 | Internal port write enable |
| int_addr | input | AW | Internal port word address |
| int_wdata | input | DW | Internal port write data |
| int_rvalid | output | 1 | Internal read data valid |
| int_rdata | output | DW | Internal read data |
| host_req | input | 1 | Host port request |
| host_we | input | 1 | Host port write enable |
| host_addr | input | AW | Host port word address |
| host_wdata | input | DW | Host port write data |
| host_ready | output | 1 | Host request accepted this cycle |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | DW | Host read data |
| inject_err | input | 1 | Store inverted parity on writes |
| err_clr | input | 1 | Clear the sticky error flag |
| err_pulse | output | 1 | Parity error on the current read result |
| err_addr | output | AW | Address of the failing read |
| err_src | output | 1 | Port of the failing read (1 = internal) |
| err_sticky | output | 1 | Sticky parity error flag |

## Verification
The bench builds the block with DW=16 and AW=4. With only 16 words, the top address and the address-zero corner are both used alongside ordinary locations, and the repair of a corrupted word can be observed directly. The full 16-bit data width keeps all-ones and all-zero data patterns in play, and these are the ones that stress the parity tree and the all-zero fault case. Collisions are staged with matching addresses on both ports, so the effect of a dropped or retried host write shows up in the stored contents.

// File: rtl/parity_shared_mem.sv
module parity_shared_mem #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_req,
  input  logic          int_we,
  input  logic [AW-1:0] int_addr,
  input  logic [DW-1:0] int_wdata,
  output logic          int_rvalid,
  output logic [DW-1:0] int_rdata,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  input  logic          inject_err,
  input  logic          err_clr,
  output logic          err_pulse,
  output logic [AW-1:0] err_addr,
  output logic          err_src,
  output logic          err_sticky
);
  localparam int DEPTH = 1 << AW;

  logic [DW:0]   mem [DEPTH];
  logic [DW:0]   rd_word;
  logic [AW-1:0] rd_addr;
  logic          rd_int, rd_host;

  logic          go, sel_int, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          par;

  assign host_ready = !int_req;
  assign sel_int    = int_req;
  assign go         = int_req || host_req;
  assign wr         = sel_int ? int_we    : host_we;
  assign addr       = sel_int ? int_addr  : host_addr;
  assign wdata      = sel_int ? int_wdata : host_wdata;
  assign par        = ~(^wdata) ^ inject_err;

  always_ff @(posedge clk) begin
    if (go && wr) mem[addr] <= {par, wdata};
    if (go && !wr) rd_word <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_int  <= 1'b0;
      rd_host <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_int  <= go && !wr && sel_int;
      rd_host <= go && !wr && !sel_int;
      if (go && !wr) rd_addr <= addr;
    end
  end

  assign int_rvalid  = rd_int;
  assign host_rvalid = rd_host;
  assign int_rdata   = rd_word[DW-1:0];
  assign host_rdata  = rd_word[DW-1:0];
  assign err_pulse   = (rd_int || rd_host) && !(^rd_word);
  assign err_addr    = rd_addr;
  assign err_src     = rd_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_sticky <= 1'b0;
    else if (err_pulse) err_sticky <= 1'b1;
    else if (err_clr)   err_sticky <= 1'b0;
  end

  AST_RVALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_rvalid && host_rvalid)); // R2
  AST_INT_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !int_we |=> int_rvalid); // R2
  AST_HOST_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_ready |=> !host_rvalid); // R3
  AST_HOST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_ready && !host_we |=> host_rvalid); // R4
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (int_rvalid || host_rvalid)); // R5
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> err_sticky); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky && !err_clr |=> err_sticky); // R7
endmodule

// File: tb/tb_parity_shared_mem.sv
module tb_parity_shared_mem;
  localparam int DW = 16;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic int_req = 0, int_we = 0, host_req = 0, host_we = 0;
  logic [AW-1:0] int_addr = '0, host_addr = '0;
  logic [DW-1:0] int_wdata = '0, host_wdata = '0;
  logic inject_err = 0, err_clr = 0;
  logic int_rvalid, host_ready, host_rvalid, err_pulse, err_src, err_sticky;
  logic [DW-1:0] int_rdata, host_rdata;
  logic [AW-1:0] err_addr;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  parity_shared_mem #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rvalid(int_rvalid), .int_rdata(int_rdata),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .inject_err(inject_err), .err_clr(err_clr), .err_pulse(err_pulse),
    .err_addr(err_addr), .err_src(err_src), .err_sticky(err_sticky)
  );

  // {port(1=int), we, inject, exp_err, addr[3:0], data[15:0]}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 16'h1234},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'h1, 16'hFFFF},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'h2, 16'h00F0},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 16'h8001},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 16'h1234},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'h1, 16'hFFFF},
    {1'b1, 1'b0, 1'b0, 1'b1, 4'h2, 16'h00F0},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h8001},
    {1'b1, 1'b1, 1'b1, 1'b0, 4'h4, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b1, 4'h4, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'h2, 16'h00F0},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'h2, 16'h00F0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit p, input bit we, input bit inj,
                    input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    inject_err = inj;
    if (p) begin
      int_req = 1; int_we = we; int_addr = a; int_wdata = d;
    end else begin
      host_req = 1; host_we = we; host_addr = a; host_wdata = d;
    end
    @(negedge clk);
    int_req = 0; host_req = 0; inject_err = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R9 host_rvalid", host_rvalid, 0);
    chk("R9 int_rvalid", int_rvalid, 0);
    chk("R9 err_pulse", err_pulse, 0);
    chk("R9 err_sticky", err_sticky, 0);
    rst_n = 1;

    chk("R4 host_ready idle", host_ready, 1);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][19:16], VEC[i][15:0]);
      if (VEC[i][22]) begin
        chk("R2 no rvalid on write", {int_rvalid, host_rvalid}, 0);
      end else begin
        chk("R2 rvalid port", {int_rvalid, host_rvalid}, VEC[i][23] ? 2'b10 : 2'b01);
        chk("R1 read data", VEC[i][23] ? int_rdata : host_rdata, VEC[i][15:0]);
        chk("R5 R6 R8 R10 err_pulse", err_pulse, VEC[i][20]);
        if (VEC[i][20]) begin
          chk("R5 err_addr", err_addr, VEC[i][19:16]);
          chk("R5 err_src", err_src, VEC[i][23]);
        end
      end
    end

    @(negedge clk);
    chk("R7 sticky held", err_sticky, 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk("R7 sticky cleared", err_sticky, 0);

    op(0, 1, 1, 4'h7, 16'hABCD);
    op(0, 0, 0, 4'h7, 16'h0);
    chk("R8 data intact", host_rdata, 16'hABCD);
    chk("R8 err_pulse", err_pulse, 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk("R7 set wins over clear", err_sticky, 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;

    op(0, 1, 0, 4'h5, 16'h5A5A);
    @(negedge clk);
    int_req = 1; int_we = 0; int_addr = 4'h5;
    host_req = 1; host_we = 1; host_addr = 4'h5; host_wdata = 16'hC3C3;
    #1 chk("R3 host_ready low", host_ready, 0);
    @(negedge clk);
    chk("R3 internal served", {int_rvalid, host_rvalid}, 2'b10);
    chk("R3 internal data", int_rdata, 16'h5A5A);
    int_req = 0; host_req = 0;
    op(0, 0, 0, 4'h5, 16'h0);
    chk("R3 stalled host write dropped", host_rdata, 16'h5A5A);

    @(negedge clk);
    int_req = 1; int_we = 1; int_addr = 4'h6; int_wdata = 16'h1111;
    host_req = 1; host_we = 1; host_addr = 4'h6; host_wdata = 16'h2222;
    @(negedge clk);
    int_req = 0;
    #1 chk("R4 host_ready after internal", host_ready, 1);
    @(negedge clk);
    host_req = 0;
    op(1, 0, 0, 4'h6, 16'h0);
    chk("R4 retried host write", int_rdata, 16'h2222);
    chk("R6 clean read", err_pulse, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule